// File: doc/BRIEF.md
# Sample-to-RAM halfword writer

The block takes 32-bit samples from an acquisition controller and stores them in an external memory that is 16 bits wide. Every accepted sample becomes two memory writes: the lower half goes out first and the upper half second. A write is a level-held request. The block raises `mem_req` with an address and a data word and keeps it high until the memory answers with `mem_ack`. It then drops the request and waits for the acknowledge to clear before it starts the next write.

A small command port sets up the target region. One command sets the base address and another sets the last offset of the region. A third command reads back the address that the next halfword will use. Each command follows a four-phase exchange on `cmd_go` and `cmd_done`.

The write pointer starts at the base and advances by one for each halfword. After the halfword at base + last offset, it returns to the base. The block holds off the sample producer with `smp_ready` while a sample is being written. It also holds it off while a command waits to run.

Top module: `smp_halfword_wr`

## Requirements
- R1: After reset, `mem_req` is low, `cmd_done` is low and `smp_ready` is high. The base, the offset and the read-back value are all zero.
- R2: The command code is on `cmd_op`: 0 sets the base, 1 sets the last offset, 2 reads the pointer and 3 does nothing. A command runs once per rise of `cmd_go`. `cmd_done` stays high until `cmd_go` falls and goes low on the following clock.
- R3: Each accepted sample yields exactly two writes. The first carries sample bits 15:0 and the second carries bits 31:16.
- R4: While `mem_ack` is low, `mem_req` stays high with a stable address and data. `mem_req` falls on the clock after `mem_ack` is seen high. It stays low while `mem_ack` remains high.
- R5: The first halfword after a base or last-offset command goes to the base. Each completed halfword then advances the address by one.
- R6: After the halfword written at base + last offset, the next one goes to the base. Address sums wrap modulo 2^AW. A last offset of 0 keeps every write at the base.
- R7: The pointer read returns, on `cmd_rdata`, the address that the next halfword will use.
- R8: `smp_ready` is low from the clock that accepts a sample until the acknowledge of its second halfword has cleared.
- R9: A command that arrives during a sample's writes completes only after both halfwords have finished. No new sample is accepted while a command is pending. Setting the base or the last offset restarts the offset at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_go | input | 1 | Command request, held high until `cmd_done` |
| cmd_op | input | 2 | Command code (0 base, 1 last offset, 2 read pointer, 3 no-op) |
| cmd_wdata | input | AW | Operand for the set commands |
| cmd_done | output | 1 | Command finished, high until `cmd_go` falls |
| cmd_rdata | output | AW | Pointer value captured by the read command |
| smp_valid | input | 1 | Sample offered |
| smp_data | input | SW | Sample word |
| smp_ready | output | 1 | Sample can be accepted this cycle |
| mem_req | output | 1 | Memory write request (level) |
| mem_addr | output | AW | Halfword address |
| mem_wdata | output | SW/2 | Halfword data |
| mem_ack | input | 1 | Memory write acknowledge |

## Verification
A wrong internal state shows at the ports within one write. A corrupted offset or a bad wrap compare puts `mem_addr` off its expected value on the very next request. The same fault shifts the value returned by a pointer read. A wrong half-select flag swaps or repeats the data halves within the same sample. A handshake state machine that skips its clear phase raises `mem_req` while `mem_ack` is still high, which shows one cycle after the acknowledge. A stuck command-done flag keeps `cmd_done` high on the clock after `cmd_go` falls.

// File: rtl/smp_hw_pkg.sv
package smp_hw_pkg;

    typedef enum logic [1:0] {
        OP_SET_BASE = 2'd0,
        OP_SET_LAST = 2'd1,
        OP_READ_PTR = 2'd2,
        OP_NOP      = 2'd3
    } cmd_op_e;

    typedef enum logic [1:0] {
        EM_IDLE = 2'd0,
        EM_REQ  = 2'd1,
        EM_CLR  = 2'd2
    } emit_st_e;

endpackage

// File: rtl/smp_hw_region.sv
module smp_hw_region
    import smp_hw_pkg::*;
#(
    parameter int AW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cmd_go,
    input  logic [1:0]    cmd_op,
    input  logic [AW-1:0] cmd_wdata,
    input  logic          emit_idle,
    input  logic          adv,
    output logic          cmd_done,
    output logic [AW-1:0] cmd_rdata,
    output logic          hold,
    output logic [AW-1:0] wr_addr
);

    localparam logic [AW-1:0] OFF_ONE = {{(AW-1){1'b0}}, 1'b1};

    typedef struct packed {
        logic [AW-1:0] base;
        logic [AW-1:0] last;
        logic [AW-1:0] off;
        logic [AW-1:0] rdata;
        logic          done;
    } region_t;

    region_t q, d;
    logic    exec;

    always_comb begin
        d    = q;
        exec = cmd_go && !q.done && emit_idle;

        if (!cmd_go) begin
            d.done = 1'b0;
        end else if (exec) begin
            d.done = 1'b1;
        end

        if (exec) begin
            case (cmd_op_e'(cmd_op))
                OP_SET_BASE: begin
                    d.base = cmd_wdata;
                    d.off  = '0;
                end
                OP_SET_LAST: begin
                    d.last = cmd_wdata;
                    d.off  = '0;
                end
                OP_READ_PTR: d.rdata = q.base + q.off;
                default: ;
            endcase
        end

        if (adv) begin
            d.off = (q.off == q.last) ? '0 : q.off + OFF_ONE;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q.base  <= '0;
            q.last  <= '1;
            q.off   <= '0;
            q.rdata <= '0;
            q.done  <= 1'b0;
        end else begin
            q <= d;
        end
    end

    assign cmd_done  = q.done;
    assign cmd_rdata = q.rdata;
    assign hold      = cmd_go && !q.done;
    assign wr_addr   = q.base + q.off;

endmodule

// File: rtl/smp_hw_emit.sv
module smp_hw_emit
    import smp_hw_pkg::*;
#(
    parameter int SW = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            smp_valid,
    input  logic [SW-1:0]   smp_data,
    input  logic            hold,
    input  logic            mem_ack,
    output logic            smp_ready,
    output logic            mem_req,
    output logic [SW/2-1:0] mem_wdata,
    output logic            adv,
    output logic            idle
);

    localparam int HW = SW / 2;

    typedef struct packed {
        emit_st_e      st;
        logic          hi;
        logic [SW-1:0] smp;
    } emit_t;

    emit_t q, d;

    always_comb begin
        d   = q;
        adv = 1'b0;
        case (q.st)
            EM_IDLE: begin
                if (smp_valid && !hold) begin
                    d.smp = smp_data;
                    d.hi  = 1'b0;
                    d.st  = EM_REQ;
                end
            end
            EM_REQ: begin
                if (mem_ack) begin
                    adv  = 1'b1;
                    d.st = EM_CLR;
                end
            end
            EM_CLR: begin
                if (!mem_ack) begin
                    if (q.hi) begin
                        d.st = EM_IDLE;
                    end else begin
                        d.hi = 1'b1;
                        d.st = EM_REQ;
                    end
                end
            end
            default: d.st = EM_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q.st  <= EM_IDLE;
            q.hi  <= 1'b0;
            q.smp <= '0;
        end else begin
            q <= d;
        end
    end

    assign idle      = (q.st == EM_IDLE);
    assign smp_ready = idle && !hold;
    assign mem_req   = (q.st == EM_REQ);
    assign mem_wdata = q.hi ? q.smp[SW-1:HW] : q.smp[HW-1:0];

endmodule

// File: rtl/smp_halfword_wr.sv
module smp_halfword_wr #(
    parameter int AW = 16,
    parameter int SW = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cmd_go,
    input  logic [1:0]      cmd_op,
    input  logic [AW-1:0]   cmd_wdata,
    output logic            cmd_done,
    output logic [AW-1:0]   cmd_rdata,
    input  logic            smp_valid,
    input  logic [SW-1:0]   smp_data,
    output logic            smp_ready,
    output logic            mem_req,
    output logic [AW-1:0]   mem_addr,
    output logic [SW/2-1:0] mem_wdata,
    input  logic            mem_ack
);

    logic hold;
    logic adv;
    logic emit_idle;

    smp_hw_region #(.AW(AW)) u_region (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_go    (cmd_go),
        .cmd_op    (cmd_op),
        .cmd_wdata (cmd_wdata),
        .emit_idle (emit_idle),
        .adv       (adv),
        .cmd_done  (cmd_done),
        .cmd_rdata (cmd_rdata),
        .hold      (hold),
        .wr_addr   (mem_addr)
    );

    smp_hw_emit #(.SW(SW)) u_emit (
        .clk       (clk),
        .rst_n     (rst_n),
        .smp_valid (smp_valid),
        .smp_data  (smp_data),
        .hold      (hold),
        .mem_ack   (mem_ack),
        .smp_ready (smp_ready),
        .mem_req   (mem_req),
        .mem_wdata (mem_wdata),
        .adv       (adv),
        .idle      (emit_idle)
    );

endmodule

// File: rtl/smp_hw_chk.sv
module smp_hw_chk #(
    parameter int AW = 16,
    parameter int SW = 32
) (
    input logic            clk,
    input logic            rst_n,
    input logic            cmd_go,
    input logic            cmd_done,
    input logic            smp_ready,
    input logic            mem_req,
    input logic [AW-1:0]   mem_addr,
    input logic [SW/2-1:0] mem_wdata,
    input logic            mem_ack
);

    // R4
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> mem_req);

    // R4
    req_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> ($stable(mem_addr) && $stable(mem_wdata)));

    // R4
    req_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_ack) |=> !mem_req);

    // R4
    ack_clear_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_req && mem_ack) |=> !mem_req);

    // R8
    ready_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        smp_ready |-> !mem_req);

    // R9
    cmd_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cmd_done) |-> !mem_req);

    // R2
    done_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_go |=> !cmd_done);

endmodule

bind smp_halfword_wr smp_hw_chk #(.AW(AW), .SW(SW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_go    (cmd_go),
    .cmd_done  (cmd_done),
    .smp_ready (smp_ready),
    .mem_req   (mem_req),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .mem_ack   (mem_ack)
);

// File: tb/sim_smp_halfword_wr.sv
module sim_smp_halfword_wr;

    localparam int AW = 16;
    localparam int SW = 32;
    localparam int HW = SW / 2;

    // {ack latency[1:0], sample[31:0]}
    localparam logic [33:0] VEC [0:7] = '{
        {2'd0, 32'h1234_5678}, {2'd1, 32'hDEAD_BEEF},
        {2'd3, 32'h0000_FFFF}, {2'd2, 32'hFFFF_0000},
        {2'd0, 32'hA5A5_5A5A}, {2'd1, 32'h0000_0001},
        {2'd2, 32'h8000_0000}, {2'd3, 32'hCAFE_F00D}
    };

    logic          clk = 1'b0;
    logic          rst_n;
    logic          cmd_go;
    logic [1:0]    cmd_op;
    logic [AW-1:0] cmd_wdata;
    logic          cmd_done;
    logic [AW-1:0] cmd_rdata;
    logic          smp_valid;
    logic [SW-1:0] smp_data;
    logic          smp_ready;
    logic          mem_req;
    logic [AW-1:0] mem_addr;
    logic [HW-1:0] mem_wdata;
    logic          mem_ack;

    always #10 clk = ~clk;

    smp_halfword_wr #(.AW(AW), .SW(SW)) u0 (
        .clk(clk), .rst_n(rst_n), .cmd_go(cmd_go), .cmd_op(cmd_op),
        .cmd_wdata(cmd_wdata), .cmd_done(cmd_done), .cmd_rdata(cmd_rdata),
        .smp_valid(smp_valid), .smp_data(smp_data), .smp_ready(smp_ready),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_ack(mem_ack)
    );

    int checks = 0;
    int fails = 0;
    bit finished = 1'b0;
    int lat = 0;
    int stretch = 0;
    logic [AW-1:0] log_addr [0:255];
    logic [HW-1:0] log_data [0:255];
    int log_n = 0;
    logic [AW-1:0] m_base, m_last, m_off, rd;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // memory model: responds away from the active edge
    initial begin
        int wcnt;
        int scnt;
        logic [AW-1:0] a0;
        logic [HW-1:0] d0;
        mem_ack = 1'b0;
        wcnt = 0;
        scnt = 0;
        forever begin
            @(negedge clk);
            if (!rst_n) begin
                mem_ack = 1'b0;
                wcnt = 0;
                scnt = 0;
            end else if (mem_ack) begin
                chk(!mem_req, "R4", "request low while ack high", 32'(mem_req), 0);
                if (scnt >= stretch) begin
                    mem_ack = 1'b0;
                    scnt = 0;
                end else begin
                    scnt++;
                end
            end else if (mem_req) begin
                if (wcnt == 0) begin
                    a0 = mem_addr;
                    d0 = mem_wdata;
                end
                if (wcnt >= lat) begin
                    chk(mem_addr == a0 && mem_wdata == d0, "R4", "address/data held",
                        {mem_addr, mem_wdata}, {a0, d0});
                    if (log_n < 256) begin
                        log_addr[log_n] = mem_addr;
                        log_data[log_n] = mem_wdata;
                        log_n++;
                    end
                    mem_ack = 1'b1;
                    wcnt = 0;
                end else begin
                    wcnt++;
                end
            end
        end
    end

    function automatic logic [AW-1:0] m_addr();
        return m_base + m_off;
    endfunction

    task automatic m_step();
        m_off = (m_off == m_last) ? '0 : m_off + 1'b1;
    endtask

    task automatic do_cmd(input logic [1:0] op, input logic [AW-1:0] wd,
                          output logic [AW-1:0] r);
        @(negedge clk);
        cmd_op = op;
        cmd_wdata = wd;
        cmd_go = 1'b1;
        while (!cmd_done) @(negedge clk);
        r = cmd_rdata;
        cmd_go = 1'b0;
        @(negedge clk);
        chk(!cmd_done, "R2", "done falls after go drops", 32'(cmd_done), 0);
    endtask

    task automatic set_base(input logic [AW-1:0] a);
        logic [AW-1:0] r;
        do_cmd(2'd0, a, r);
        m_base = a;
        m_off = '0;
    endtask

    task automatic set_last(input logic [AW-1:0] l);
        logic [AW-1:0] r;
        do_cmd(2'd1, l, r);
        m_last = l;
        m_off = '0;
    endtask

    task automatic push(input logic [SW-1:0] d);
        @(negedge clk);
        smp_valid = 1'b1;
        smp_data = d;
        while (!smp_ready) @(negedge clk);
        @(negedge clk);
        smp_valid = 1'b0;
    endtask

    task automatic drain();
        @(negedge clk);
        while (!smp_ready) @(negedge clk);
    endtask

    task automatic check_pair(input logic [SW-1:0] d, input int idx);
        logic [AW-1:0] e0, e1;
        e0 = m_addr(); m_step();
        e1 = m_addr(); m_step();
        chk(log_data[idx] == d[HW-1:0], "R3", "low half first", 32'(log_data[idx]), 32'(d[HW-1:0]));
        chk(log_data[idx+1] == d[SW-1:HW], "R3", "high half second", 32'(log_data[idx+1]), 32'(d[SW-1:HW]));
        chk(log_addr[idx] == e0, "R5", "first halfword address", 32'(log_addr[idx]), 32'(e0));
        chk(log_addr[idx+1] == e1, "R5", "second halfword address", 32'(log_addr[idx+1]), 32'(e1));
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        int n0;
        rst_n = 1'b0;
        cmd_go = 1'b0;
        cmd_op = 2'd0;
        cmd_wdata = '0;
        smp_valid = 1'b0;
        smp_data = '0;
        m_base = '0;
        m_last = '1;
        m_off = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk(smp_ready, "R1", "ready after reset", 32'(smp_ready), 1);
        chk(!mem_req, "R1", "no request after reset", 32'(mem_req), 0);
        chk(!cmd_done, "R1", "done low after reset", 32'(cmd_done), 0);
        chk(cmd_rdata == '0, "R1", "read-back zero", 32'(cmd_rdata), 0);
        do_cmd(2'd2, '0, rd);
        chk(rd == '0, "R1", "pointer zero after reset", 32'(rd), 0);

        // R2 no-op changes nothing
        do_cmd(2'd3, 16'h1234, rd);
        do_cmd(2'd2, '0, rd);
        chk(rd == '0, "R2", "no-op leaves pointer", 32'(rd), 0);

        set_base(16'h0100);
        set_last(16'd5);
        do_cmd(2'd2, '0, rd);
        chk(rd == 16'h0100, "R7", "pointer at base", 32'(rd), 32'h100);

        // table walk: R3, R5, and R6 wrap (16 halfwords over a 6-halfword region)
        for (int i = 0; i < 8; i++) begin
            lat = int'(VEC[i][33:32]);
            stretch = i % 2;
            n0 = log_n;
            push(VEC[i][31:0]);
            drain();
            chk(log_n == n0 + 2, "R3", "two writes per sample", 32'(log_n - n0), 2);
            check_pair(VEC[i][31:0], n0);
        end

        do_cmd(2'd2, '0, rd);
        chk(rd == m_addr(), "R7", "pointer after table", 32'(rd), 32'(m_addr()));

        // R6 modular wrap through the top of the address space
        lat = 0;
        stretch = 0;
        set_base(16'hFFFF);
        set_last(16'd3);
        n0 = log_n;
        push(32'h1111_2222);
        drain();
        push(32'h3333_4444);
        drain();
        check_pair(32'h1111_2222, n0);
        check_pair(32'h3333_4444, n0 + 2);
        chk(log_addr[n0+1] == 16'h0000, "R6", "address wraps modulo", 32'(log_addr[n0+1]), 0);
        do_cmd(2'd2, '0, rd);
        chk(rd == 16'hFFFF, "R6", "pointer back at base", 32'(rd), 32'hFFFF);

        // R8 ready low for the whole pair
        lat = 3;
        stretch = 1;
        n0 = log_n;
        push(32'h5555_6666);
        chk(!smp_ready, "R8", "ready low after accept", 32'(smp_ready), 0);
        while (!smp_ready) @(negedge clk);
        chk(log_n == n0 + 2, "R8", "ready returns only after pair", 32'(log_n - n0), 2);
        check_pair(32'h5555_6666, n0);

        // R9 command during a pair, with a sample waiting
        lat = 2;
        stretch = 0;
        n0 = log_n;
        push(32'h7777_8888);
        fork
            do_cmd(2'd2, '0, rd);
            push(32'h9999_AAAA);
        join
        drain();
        check_pair(32'h7777_8888, n0);
        chk(rd == m_addr(), "R9", "command waits for pair, blocks sample", 32'(rd), 32'(m_addr()));
        check_pair(32'h9999_AAAA, n0 + 2);

        // R9 last-offset write restarts the offset; R6 last offset zero
        set_base(16'h0200);
        n0 = log_n;
        push(32'hBBBB_CCCC);
        drain();
        check_pair(32'hBBBB_CCCC, n0);
        set_last(16'd0);
        n0 = log_n;
        push(32'hDDDD_EEEE);
        drain();
        chk(log_addr[n0] == 16'h0200, "R9", "offset restarts at base", 32'(log_addr[n0]), 32'h200);
        chk(log_addr[n0+1] == 16'h0200, "R6", "last offset zero stays at base", 32'(log_addr[n0+1]), 32'h200);
        check_pair(32'hDDDD_EEEE, n0);

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule